// File: doc/BRIEF.md
# Console Keyboard Input Controller

This block sits between a keyboard that delivers 7-bit ASCII bytes and a 6-bit character channel. Keystrokes arrive on a valid/ready port. While a transfer is active, each printable key is folded into a 6-bit code and offered to the channel write port. Control keys do not go to the channel. They terminate or flag the transfer through a status word.

A processor drives the block through a small command/response port. A start command opens a transfer and a stop command closes it. The processor polls the status word, and a read strobe clears every bit of that word except busy. A per-device done flag tells the processor that something worth reading has happened. An escape key followed by a digit records a function-key press. Malformed input produces a one-cycle error pulse.

Top module: `kbd_chan_ctrl`

## Requirements
- R1: After reset, stat_word is 0, done is 0, chr_valid is 0, err_pulse is 0 and key_ready is 1.
- R2: A command with cmd_bits[0] set (start) clears end (status bit 0), sets busy (status bit 5) and clears done. A command with cmd_bits[1] set (stop) sets end, clears busy and sets done. When both bits are set, stop wins. Each takes effect on the clock edge that accepts the command.
- R3: During a cycle with stat_rd high, stat_word carries the full status. After that edge every bit except busy is zero and done is low. A key event, command or end of record in the same cycle is applied after the clear and is kept.
- R4: While busy, a key code c (after masking, c ≥ 040 octal, not a control key) is folded as follows. If c ≥ 0140, subtract 040. Then, if the result is ≥ 0100, subtract 040. Otherwise, if it is ≥ 060, subtract 060; otherwise, if it is ≥ 040, subtract 020. The 6-bit result is offered on chr_data one cycle after the key is accepted.
- R5: A pending character keeps chr_valid high and chr_data stable until chr_ready. key_ready is low whenever a character is pending.
- R6: When a character is taken with chr_eor high, busy clears, end sets and done sets.
- R7: While busy, CR (015) or LF (012) sets accept (bit 8) and end, clears busy and sets done.
- R8: Ctrl-X (030) sets input (bit 6) and done. If busy, it also sets end and clears busy.
- R9: Ctrl-C (003) or Ctrl-U (025) sets cancel (bit 7) and done. If busy, it also sets end and clears busy.
- R10: ESC (033) arms a one-key prefix. A following digit 1 to 5 sets function bit 8+n (F1 is bit 9) and done. Any other following key raises err_pulse. Either way the prefix is cleared.
- R11: A printable key while not busy, CR/LF while not busy, or any other control code below 040 raises err_pulse for one cycle. It produces no character and leaves the status unchanged.
- R12: Bit 7 of key_data is ignored: 0xC1 behaves exactly as 0x41.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Keystroke present |
| key_data | input | 8 | Keystroke byte |
| key_ready | output | 1 | Keystroke can be accepted |
| cmd_valid | input | 1 | Command strobe |
| cmd_bits | input | 2 | Bit 0 start, bit 1 stop |
| stat_rd | input | 1 | Status read strobe (clears status) |
| stat_word | output | 14 | Status word |
| done | output | 1 | Device done flag |
| chr_valid | output | 1 | 6-bit character offered to channel |
| chr_data | output | 6 | Folded character code |
| chr_ready | input | 1 | Channel accepts the character |
| chr_eor | input | 1 | Channel end of record, qualified by the handshake |
| err_pulse | output | 1 | One-cycle rejected-key indication |

## Verification
Several properties are checked on every cycle: busy and end are never set together, start and stop act on the following cycle, a read clears the word, channel backpressure holds the character steady and blocks the keyboard, and end of record closes the transfer. Other behaviour can only be shown by the bench's scenarios, because it depends on which key arrived: the exact folded codes, the status patterns for enter, cancel and post-input keys in both the busy and idle state, the escape prefix and how it is cleared, and masking of the key's top bit.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

  localparam int KEY_BITS  = 8;
  localparam int CHR_BITS  = 6;
  localparam int FIDX_BITS = 4;

  // status bit positions (the processor decodes these)
  localparam int ST_END    = 0;
  localparam int ST_BUSY   = 5;
  localparam int ST_INPUT  = 6;
  localparam int ST_CANCEL = 7;
  localparam int ST_ACCEPT = 8;
  localparam int ST_FKEY0  = 9;

  localparam logic [6:0] ASC_ETX   = 7'o003;
  localparam logic [6:0] ASC_LF    = 7'o012;
  localparam logic [6:0] ASC_CR    = 7'o015;
  localparam logic [6:0] ASC_NAK   = 7'o025;
  localparam logic [6:0] ASC_CAN   = 7'o030;
  localparam logic [6:0] ASC_ESC   = 7'o033;
  localparam logic [6:0] ASC_SPACE = 7'o040;
  localparam logic [6:0] ASC_ONE   = 7'o061;

  typedef enum logic [2:0] {
    KC_ERROR  = 3'd0,
    KC_CHAR   = 3'd1,
    KC_ENTER  = 3'd2,
    KC_ESC    = 3'd3,
    KC_POST   = 3'd4,
    KC_CANCEL = 3'd5,
    KC_FKEY   = 3'd6
  } key_class_e;

  typedef struct packed {
    key_class_e             kclass;
    logic                   ends;   // key terminates the running transfer
    logic [FIDX_BITS-1:0]   fidx;
    logic [CHR_BITS-1:0]    code;
  } key_evt_t;

  // lower-case/upper-case/digit fold into the 6-bit character set
  function automatic logic [CHR_BITS-1:0] fold_char(input logic [KEY_BITS-1:0] c);
    logic [KEY_BITS-1:0] t;
    t = c;
    if (t >= KEY_BITS'(8'o140)) t = t - KEY_BITS'(8'o040);
    if (t >= KEY_BITS'(8'o100))      t = t - KEY_BITS'(8'o040);
    else if (t >= KEY_BITS'(8'o060)) t = t - KEY_BITS'(8'o060);
    else if (t >= KEY_BITS'(8'o040)) t = t - KEY_BITS'(8'o020);
    return CHR_BITS'(t);
  endfunction

endpackage

// File: rtl/kbd_decode.sv
module kbd_decode
  import kbd_pkg::*;
#(
  parameter int KEY_W     = KEY_BITS,
  parameter int NUM_FKEYS = 5
) (
  input  logic [KEY_W-1:0] key_data,
  input  logic             busy,
  input  logic             esc_armed,
  output key_evt_t         evt
);

  localparam logic [KEY_W-1:0] ASCII_MASK = KEY_W'(7'h7F);
  localparam logic [KEY_W-1:0] K_ETX   = KEY_W'(ASC_ETX);
  localparam logic [KEY_W-1:0] K_LF    = KEY_W'(ASC_LF);
  localparam logic [KEY_W-1:0] K_CR    = KEY_W'(ASC_CR);
  localparam logic [KEY_W-1:0] K_NAK   = KEY_W'(ASC_NAK);
  localparam logic [KEY_W-1:0] K_CAN   = KEY_W'(ASC_CAN);
  localparam logic [KEY_W-1:0] K_ESC   = KEY_W'(ASC_ESC);
  localparam logic [KEY_W-1:0] K_SPACE = KEY_W'(ASC_SPACE);
  localparam logic [KEY_W-1:0] K_ONE   = KEY_W'(ASC_ONE);
  localparam logic [KEY_W-1:0] K_FEND  = KEY_W'(int'(ASC_ONE) + NUM_FKEYS);

  logic [KEY_W-1:0] c;
  logic [KEY_W-1:0] fofs;

  assign c    = key_data & ASCII_MASK;
  assign fofs = c - K_ONE;

  always_comb begin
    evt        = '0;
    evt.kclass = KC_ERROR;
    evt.code   = fold_char(KEY_BITS'(c));
    if (esc_armed) begin
      if (c >= K_ONE && c < K_FEND) begin
        evt.kclass = KC_FKEY;
        evt.fidx   = FIDX_BITS'(fofs);
      end
    end else if (c == K_ESC) begin
      evt.kclass = KC_ESC;
    end else if (c == K_CAN) begin
      evt.kclass = KC_POST;
      evt.ends   = busy;
    end else if (c == K_ETX || c == K_NAK) begin
      evt.kclass = KC_CANCEL;
      evt.ends   = busy;
    end else if (c == K_CR || c == K_LF) begin
      if (busy) begin
        evt.kclass = KC_ENTER;
        evt.ends   = 1'b1;
      end
    end else if (busy && c >= K_SPACE) begin
      evt.kclass = KC_CHAR;
    end
  end

endmodule

// File: rtl/kbd_status.sv
module kbd_status
  import kbd_pkg::*;
#(
  parameter int NUM_FKEYS = 5,
  localparam int STAT_W   = ST_FKEY0 + NUM_FKEYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              stat_rd,
  input  logic              evt_fire,
  input  key_evt_t          evt,
  input  logic              eor_fire,
  output logic [STAT_W-1:0] status,
  output logic              done,
  output logic              esc_armed,
  output logic              err_pulse
);

  localparam logic [STAT_W-1:0] BUSY_MASK = STAT_W'(1) << ST_BUSY;

  logic [STAT_W-1:0] status_q, status_d;
  logic              done_q, done_d;
  logic              armed_q, armed_d;
  logic              err_q, err_d;
  logic              upd_en;

  assign upd_en = stat_rd | cmd_valid | evt_fire | eor_fire;

  // next state: read clear, then command, then key event, then end of record
  always_comb begin
    status_d = status_q;
    done_d   = done_q;
    armed_d  = armed_q;
    err_d    = 1'b0;

    if (stat_rd) begin
      status_d = status_d & BUSY_MASK;
      done_d   = 1'b0;
    end

    if (cmd_valid && cmd_start) begin
      status_d[ST_END]  = 1'b0;
      status_d[ST_BUSY] = 1'b1;
      done_d            = 1'b0;
    end
    if (cmd_valid && cmd_stop) begin
      status_d[ST_END]  = 1'b1;
      status_d[ST_BUSY] = 1'b0;
      done_d            = 1'b1;
    end

    if (evt_fire) begin
      unique case (evt.kclass)
        KC_ENTER: begin
          status_d[ST_ACCEPT] = 1'b1;
          done_d              = 1'b1;
        end
        KC_ESC: armed_d = 1'b1;
        KC_POST: begin
          status_d[ST_INPUT] = 1'b1;
          done_d             = 1'b1;
          armed_d            = 1'b0;
        end
        KC_CANCEL: begin
          status_d[ST_CANCEL] = 1'b1;
          done_d              = 1'b1;
          armed_d             = 1'b0;
        end
        KC_FKEY: begin
          status_d[ST_FKEY0 + int'(evt.fidx)] = 1'b1;
          done_d  = 1'b1;
          armed_d = 1'b0;
        end
        KC_ERROR: begin
          err_d   = 1'b1;
          armed_d = 1'b0;
        end
        default: ;
      endcase
      if (evt.ends) begin
        status_d[ST_END]  = 1'b1;
        status_d[ST_BUSY] = 1'b0;
      end
    end

    if (eor_fire) begin
      status_d[ST_END]  = 1'b1;
      status_d[ST_BUSY] = 1'b0;
      done_d            = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      done_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else if (upd_en) begin
      status_q <= status_d;
      done_q   <= done_d;
      armed_q  <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign status    = status_q;
  assign done      = done_q;
  assign esc_armed = armed_q;
  assign err_pulse = err_q;

endmodule

// File: rtl/kbd_chan_out.sv
module kbd_chan_out #(
  parameter int CHR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CHR_W-1:0] load_code,
  input  logic             chr_ready,
  output logic             chr_valid,
  output logic [CHR_W-1:0] chr_data
);

  logic             valid_q, valid_d;
  logic [CHR_W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (load)                     valid_d = 1'b1;
    else if (valid_q && chr_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= load_code;
  end

  assign chr_valid = valid_q;
  assign chr_data  = data_q;

endmodule

// File: rtl/kbd_chan_ctrl.sv
module kbd_chan_ctrl
  import kbd_pkg::*;
#(
  parameter int KEY_W     = KEY_BITS,
  parameter int CHR_W     = CHR_BITS,
  parameter int NUM_FKEYS = 5,
  localparam int STAT_W   = ST_FKEY0 + NUM_FKEYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_data,
  output logic              key_ready,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_bits,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_word,
  output logic              done,
  output logic              chr_valid,
  output logic [CHR_W-1:0]  chr_data,
  input  logic              chr_ready,
  input  logic              chr_eor,
  output logic              err_pulse
);

  logic [1:0]  rst_pipe;
  logic        rst_core_n;
  key_evt_t    evt;
  logic        esc_armed;
  logic        key_fire;
  logic        eor_fire;
  logic        load_chr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign key_ready = ~chr_valid;
  assign key_fire  = key_valid & key_ready;
  assign eor_fire  = chr_valid & chr_ready & chr_eor;
  assign load_chr  = key_fire & (evt.kclass == KC_CHAR);

  kbd_decode #(
    .KEY_W     (KEY_W),
    .NUM_FKEYS (NUM_FKEYS)
  ) u_decode (
    .key_data  (key_data),
    .busy      (stat_word[ST_BUSY]),
    .esc_armed (esc_armed),
    .evt       (evt)
  );

  kbd_status #(
    .NUM_FKEYS (NUM_FKEYS)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_valid (cmd_valid),
    .cmd_start (cmd_bits[0]),
    .cmd_stop  (cmd_bits[1]),
    .stat_rd   (stat_rd),
    .evt_fire  (key_fire),
    .evt       (evt),
    .eor_fire  (eor_fire),
    .status    (stat_word),
    .done      (done),
    .esc_armed (esc_armed),
    .err_pulse (err_pulse)
  );

  kbd_chan_out #(
    .CHR_W (CHR_W)
  ) u_chan_out (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (load_chr),
    .load_code (evt.code[CHR_W-1:0]),
    .chr_ready (chr_ready),
    .chr_valid (chr_valid),
    .chr_data  (chr_data)
  );

endmodule

// File: rtl/kbd_chan_ctrl_chk.sv
module kbd_chan_ctrl_chk #(
  parameter int KEY_W     = 8,
  parameter int CHR_W     = 6,
  parameter int NUM_FKEYS = 5,
  localparam int STAT_W   = 9 + NUM_FKEYS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic [KEY_W-1:0]  key_data,
  input logic              key_ready,
  input logic              cmd_valid,
  input logic [1:0]        cmd_bits,
  input logic              stat_rd,
  input logic [STAT_W-1:0] stat_word,
  input logic              done,
  input logic              chr_valid,
  input logic [CHR_W-1:0]  chr_data,
  input logic              chr_ready,
  input logic              chr_eor,
  input logic              err_pulse
);

  localparam int BIT_END  = 0;
  localparam int BIT_BUSY = 5;

  logic kfire, efire;
  assign kfire = key_valid && key_ready;
  assign efire = chr_valid && chr_ready && chr_eor;

  AST_BUSY_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_word[BIT_BUSY] && stat_word[BIT_END])); // R2

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_bits[0] && !cmd_bits[1] && !kfire && !efire
    |=> stat_word[BIT_BUSY] && !stat_word[BIT_END] && !done); // R2

  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_bits[1] |=> !stat_word[BIT_BUSY] && stat_word[BIT_END] && done); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !cmd_valid && !kfire && !efire
    |=> ((stat_word & ~(STAT_W'(1) << BIT_BUSY)) == '0) && !done); // R3

  AST_CHAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && !chr_ready |=> chr_valid && $stable(chr_data)); // R5

  AST_KEY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> !key_ready); // R5

  AST_EOR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    efire |=> !stat_word[BIT_BUSY] && stat_word[BIT_END] && done); // R6

  AST_ERR_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !$rose(chr_valid)); // R11

endmodule

bind kbd_chan_ctrl kbd_chan_ctrl_chk #(
  .KEY_W     (KEY_W),
  .CHR_W     (CHR_W),
  .NUM_FKEYS (NUM_FKEYS)
) u_chk (.*);

// File: tb/kbd_chan_ctrl_tb.sv
module kbd_chan_ctrl_tb;

  localparam logic [13:0] S_END  = 14'h001;
  localparam logic [13:0] S_BUSY = 14'h020;
  localparam logic [13:0] S_INP  = 14'h040;
  localparam logic [13:0] S_CAN  = 14'h080;
  localparam logic [13:0] S_ACC  = 14'h100;
  localparam logic [13:0] S_F1   = 14'h200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_valid;
  logic [7:0]  key_data;
  logic        key_ready;
  logic        cmd_valid;
  logic [1:0]  cmd_bits;
  logic        stat_rd;
  logic [13:0] stat_word;
  logic        done;
  logic        chr_valid;
  logic [5:0]  chr_data;
  logic        chr_ready;
  logic        chr_eor;
  logic        err_pulse;

  always #4 clk = ~clk;

  kbd_chan_ctrl u_dut (
    .clk (clk), .rst_n (rst_n),
    .key_valid (key_valid), .key_data (key_data), .key_ready (key_ready),
    .cmd_valid (cmd_valid), .cmd_bits (cmd_bits),
    .stat_rd (stat_rd), .stat_word (stat_word), .done (done),
    .chr_valid (chr_valid), .chr_data (chr_data),
    .chr_ready (chr_ready), .chr_eor (chr_eor),
    .err_pulse (err_pulse)
  );

  typedef struct { logic [5:0] code; logic eor; string req; } exp_t;
  exp_t q[$];

  int   checks = 0;
  int   errors = 0;
  logic stall = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  logic prev_hold = 1'b0;
  logic [5:0] prev_data = '0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // channel side: ready pattern and end-of-record tag for the head item
  always @(negedge clk) begin
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    chr_ready = stall ? lfsr[0] : 1'b1;
    chr_eor   = (q.size() > 0) ? q[0].eor : 1'b0;
  end

  // monitor: pops expected characters as the channel takes them
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (chr_valid) begin
        if (key_ready) begin
          checks++; errors++;
          $display("FAIL R5 key_ready: actual 1 expected 0");
        end
        if (prev_hold) chk("R5", "held chr_data", chr_data, prev_data);
      end
      if (chr_valid && chr_ready) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected char: actual 0x%0h expected none", chr_data);
        end else begin
          chk(q[0].req, "chr_data", chr_data, q[0].code);
          void'(q.pop_front());
        end
      end
      prev_hold = chr_valid && !chr_ready;
      prev_data = chr_data;
    end
  end

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic send_key(input logic [7:0] b, input logic rd);
    while (!key_ready) tick();
    key_valid = 1'b1;
    key_data  = b;
    stat_rd   = rd;
    tick();
    key_valid = 1'b0;
    stat_rd   = 1'b0;
    #1;
  endtask

  task automatic push_char(input logic [7:0] b, input logic [5:0] code,
                           input logic eor, input string req);
    exp_t e;
    e.code = code; e.eor = eor; e.req = req;
    q.push_back(e);
    send_key(b, 1'b0);
  endtask

  task automatic command(input logic [1:0] bits);
    cmd_valid = 1'b1;
    cmd_bits  = bits;
    tick();
    cmd_valid = 1'b0;
    cmd_bits  = 2'b00;
    #1;
  endtask

  task automatic read_stat(input logic [13:0] exp);
    stat_rd = 1'b1;
    #1;
    chk("R3", "read response", stat_word, exp);
    tick();
    stat_rd = 1'b0;
    #1;
    chk("R3", "after read", stat_word, exp & S_BUSY);
    chk("R3", "done after read", done, 0);
  endtask

  task automatic drain;
    while (q.size() != 0 || chr_valid) tick();
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; key_data = '0;
    cmd_valid = 1'b0; cmd_bits = '0; stat_rd = 1'b0;
    chr_ready = 1'b1; chr_eor = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    #1;
    // R1 reset state
    chk("R1", "stat_word", stat_word, 0);
    chk("R1", "done", done, 0);
    chk("R1", "chr_valid", chr_valid, 0);
    chk("R1", "err_pulse", err_pulse, 0);
    chk("R1", "key_ready", key_ready, 1);

    // R2 start
    command(2'b01);
    chk("R2", "start status", stat_word, S_BUSY);
    chk("R2", "start done", done, 0);

    // R4 folding under channel stalls, R12 top bit ignored
    stall = 1'b1;
    push_char(8'h41, 6'h21, 1'b0, "R4");
    push_char(8'h61, 6'h21, 1'b0, "R4");
    push_char(8'h30, 6'h00, 1'b0, "R4");
    push_char(8'h20, 6'h10, 1'b0, "R4");
    push_char(8'h40, 6'h20, 1'b0, "R4");
    push_char(8'h7F, 6'h3F, 1'b0, "R4");
    push_char(8'h35, 6'h05, 1'b0, "R4");
    push_char(8'h23, 6'h13, 1'b0, "R4");
    push_char(8'hC1, 6'h21, 1'b0, "R12");
    drain();
    stall = 1'b0;
    push_char(8'h7A, 6'h3A, 1'b0, "R4");
    push_char(8'h7E, 6'h3E, 1'b0, "R4");
    drain();
    chk("R4", "still busy", stat_word, S_BUSY);

    // R7 enter while busy
    send_key(8'h0D, 1'b0);
    chk("R7", "CR status", stat_word, S_ACC | S_END);
    chk("R7", "CR done", done, 1);
    read_stat(S_ACC | S_END);

    // R11 printable while idle
    send_key(8'h42, 1'b0);
    chk("R11", "err idle printable", err_pulse, 1);
    chk("R11", "status unchanged", stat_word, 0);
    chk("R11", "no char", chr_valid, 0);
    tick(); #1;
    chk("R11", "err one cycle", err_pulse, 0);

    // R8 post-input while idle
    send_key(8'h18, 1'b0);
    chk("R8", "ctrl-X idle", stat_word, S_INP);
    chk("R8", "ctrl-X done", done, 1);
    read_stat(S_INP);

    // R9 cancel busy and idle
    command(2'b01);
    send_key(8'h15, 1'b0);
    chk("R9", "ctrl-U busy", stat_word, S_CAN | S_END);
    chk("R9", "ctrl-U done", done, 1);
    read_stat(S_CAN | S_END);
    send_key(8'h03, 1'b0);
    chk("R9", "ctrl-C idle", stat_word, S_CAN);
    read_stat(S_CAN);

    // R10 function keys and prefix
    send_key(8'h1B, 1'b0);
    chk("R10", "esc no status", stat_word, 0);
    chk("R10", "esc no done", done, 0);
    send_key(8'h33, 1'b0);
    chk("R10", "F3", stat_word, S_F1 << 2);
    chk("R10", "F3 done", done, 1);
    read_stat(S_F1 << 2);
    send_key(8'h1B, 1'b0);
    send_key(8'h78, 1'b0);
    chk("R10", "bad digit err", err_pulse, 1);
    chk("R10", "bad digit status", stat_word, 0);
    send_key(8'h18, 1'b0);
    chk("R10", "prefix cleared", stat_word, S_INP);
    read_stat(S_INP);
    command(2'b01);
    send_key(8'h1B, 1'b0);
    send_key(8'h31, 1'b0);
    chk("R10", "F1 busy", stat_word, S_F1 | S_BUSY);
    read_stat(S_F1 | S_BUSY);

    // R11 control code while busy
    send_key(8'h01, 1'b0);
    chk("R11", "ctrl-A err", err_pulse, 1);
    chk("R11", "ctrl-A status", stat_word, S_BUSY);
    chk("R11", "ctrl-A no char", chr_valid, 0);

    // R3 read with a key event in the same cycle
    send_key(8'h18, 1'b1);
    chk("R3", "event kept over read", stat_word, S_INP | S_END);
    chk("R3", "done kept", done, 1);
    read_stat(S_INP | S_END);

    // R6 end of record
    command(2'b01);
    push_char(8'h4B, 6'h2B, 1'b1, "R6");
    drain();
    chk("R6", "eor status", stat_word, S_END);
    chk("R6", "eor done", done, 1);
    read_stat(S_END);

    // R2 stop and start+stop
    command(2'b01);
    command(2'b10);
    chk("R2", "stop status", stat_word, S_END);
    chk("R2", "stop done", done, 1);
    read_stat(S_END);
    command(2'b11);
    chk("R2", "stop wins", stat_word, S_END);
    chk("R2", "stop wins done", done, 1);
    read_stat(S_END);

    // R7 line feed
    command(2'b01);
    send_key(8'h0A, 1'b0);
    chk("R7", "LF status", stat_word, S_ACC | S_END);
    read_stat(S_ACC | S_END);

    repeat (4) tick();
    chk("R4", "queue empty", q.size(), 0);
    finish_run();
  end

endmodule